// File: doc/BRIEF.md
# Card identification state machine

This block is the card side of the identification phase on a shared command bus. It takes command tokens that have already been deframed and checked elsewhere. Each token is an index, a 32-bit argument and a flag that says whether the command was broadcast. The block moves the card through five states: idle, ready, identification, standby and inactive. One card model covers both kinds of card. A memory card runs the sequence operating-condition exchange, identification-number exchange, address assignment. An I/O card leaves out the identification-number step. The `io_mode` pin chooses the kind, and the block samples it only while reset is held.

For each command the block either raises a one-cycle response request or stays silent. A response request carries one of three payloads: the supported-range word, the 128-bit card identifier, or an acknowledge that echoes the new relative address. The block stores the relative address. It also drives a mode bit for the command-line output stage, which selects open-drain before the card has an address and push-pull after. Bit framing, CRC and data transfer happen in other blocks.

Top module: `card_ident_fsm`

## Requirements
- R1: While reset is held and right after it is released: `state` is 0 (idle), `rca` is 0, `rsp_valid` is 0 and `drv_push_pull` is 0 (open-drain).
- R2: A memory card in idle receives a broadcast index 41 whose immediately preceding command was index 55, and `cmd_arg[23:0] & ocr_cfg` is nonzero. One cycle later it raises `rsp_valid` with `rsp_kind`=1 and `rsp_data` equal to `ocr_cfg` zero-extended, and `state` becomes 1 (ready).
- R3: If that operating-condition exchange (index 41 on a memory card, index 5 on an I/O card) has a zero overlap, the card still returns the kind-1 response, then moves to `state` 4 (inactive). In inactive it ignores every later command.
- R4: Index 41 is taken as the application command only when the command just before it was index 55. Any other command in between clears that pending condition.
- R5: A memory card in ready receives broadcast index 2. It raises `rsp_kind`=2 with `rsp_data` equal to `cid_cfg`, and `state` becomes 2 (identification).
- R6: A non-broadcast index 3 on a memory card in identification, or on an I/O card in ready, does three things. It stores `cmd_arg[31:16]` in `rca`, returns `rsp_kind`=3 with `rsp_data[31:16]` equal to the new address and all other bits zero, and sets `state` to 3 (standby).
- R7: A non-broadcast index 3 in standby replaces `rca` with the new value and acknowledges it. The stored address is always the last one assigned.
- R8: In standby, broadcasts with index 2, 5 or 41 produce no response and do not change state.
- R9: `drv_push_pull` is 1 exactly when `state` is 3 (standby).
- R10: An I/O card answers broadcast index 5 in idle the way R2 and R3 describe, and it ignores index 2 and index 41.
- R11: A command that is not legal in the current state produces no response and leaves `state` and `rca` unchanged. This includes a wrong broadcast flag: indices 2, 5 and 41 must be broadcast, and index 3 must not be.
- R12: `io_mode` is sampled only while reset is held. Changing it after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_mode | input | 1 | 1 selects I/O-card behaviour; sampled during reset |
| ocr_cfg | input | 24 | Supported operating-range mask |
| cid_cfg | input | 128 | Card identification number |
| cmd_valid | input | 1 | Command token present this cycle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_bcast | input | 1 | Command was broadcast |
| rsp_valid | output | 1 | One-cycle response request |
| rsp_kind | output | 2 | 1 range word, 2 identifier, 3 address acknowledge |
| rsp_data | output | 128 | Response payload |
| state | output | 3 | 0 idle, 1 ready, 2 ident, 3 standby, 4 inactive |
| rca | output | 16 | Stored relative address |
| drv_push_pull | output | 1 | 1 push-pull, 0 open-drain |

## Verification
A wrong state shows up as soon as the next command arrives. The card either answers a command it should skip or stays silent when it should reply, and `rsp_valid` shows this one cycle after the token. A standby or inactive state that was entered by mistake, or left by mistake, also changes `drv_push_pull` or the `state` output at the same edge. An application-command pending flag that is held or cleared at the wrong moment can only be seen on the next index-41 token. For that reason the stimulus places index 41 both right after index 55 and after an unrelated command in between.

// File: rtl/card_ident_fsm.sv
module card_ident_fsm #(
  parameter int OCR_W = 24,
  parameter int CID_W = 128,
  parameter int RCA_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_mode,
  input  logic [OCR_W-1:0] ocr_cfg,
  input  logic [CID_W-1:0] cid_cfg,
  input  logic             cmd_valid,
  input  logic [5:0]       cmd_index,
  input  logic [31:0]      cmd_arg,
  input  logic             cmd_bcast,
  output logic             rsp_valid,
  output logic [1:0]       rsp_kind,
  output logic [CID_W-1:0] rsp_data,
  output logic [2:0]       state,
  output logic [RCA_W-1:0] rca,
  output logic             drv_push_pull
);
  localparam logic [2:0] S_IDLE = 3'd0, S_READY = 3'd1, S_IDENT = 3'd2,
                         S_STBY = 3'd3, S_INACT = 3'd4;
  localparam logic [5:0] C_CID = 6'd2, C_ADDR = 6'd3, C_IOOP = 6'd5,
                         C_MEMOP = 6'd41, C_APP = 6'd55;
  localparam logic [1:0] K_OCR = 2'd1, K_CID = 2'd2, K_ACK = 2'd3;

  logic             is_io, app_pend, nxt_app;
  logic [2:0]       nxt_st;
  logic [RCA_W-1:0] nxt_rca;
  logic             r_v;
  logic [1:0]       r_k;
  logic [CID_W-1:0] r_d;

  wire fits      = |(cmd_arg[OCR_W-1:0] & ocr_cfg);
  wire op_ok     = cmd_bcast && state == S_IDLE &&
                   (is_io ? cmd_index == C_IOOP : (cmd_index == C_MEMOP && app_pend));
  wire cid_ok    = cmd_bcast && !is_io && cmd_index == C_CID && state == S_READY;
  wire addr_ok   = !cmd_bcast && cmd_index == C_ADDR &&
                   (state == S_STBY || state == (is_io ? S_READY : S_IDENT));
  wire [RCA_W-1:0] new_rca = cmd_arg[31 -: RCA_W];

  always_comb begin
    nxt_st  = state;
    nxt_rca = rca;
    nxt_app = app_pend;
    r_v = 1'b0;
    r_k = 2'd0;
    r_d = '0;
    if (cmd_valid && state != S_INACT) begin
      nxt_app = (cmd_index == C_APP);
      if (op_ok) begin
        r_v = 1'b1; r_k = K_OCR; r_d = CID_W'(ocr_cfg);
        nxt_st = fits ? S_READY : S_INACT;
      end else if (cid_ok) begin
        r_v = 1'b1; r_k = K_CID; r_d = cid_cfg;
        nxt_st = S_IDENT;
      end else if (addr_ok) begin
        r_v = 1'b1; r_k = K_ACK; r_d = CID_W'({new_rca, {RCA_W{1'b0}}});
        nxt_st = S_STBY; nxt_rca = new_rca;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_io     <= io_mode;
      app_pend  <= 1'b0;
      state     <= S_IDLE;
      rca       <= '0;
      rsp_valid <= 1'b0;
      rsp_kind  <= 2'd0;
      rsp_data  <= '0;
    end else begin
      app_pend  <= nxt_app;
      state     <= nxt_st;
      rca       <= nxt_rca;
      rsp_valid <= r_v;
      rsp_kind  <= r_k;
      rsp_data  <= r_d;
    end
  end

  assign drv_push_pull = (state == S_STBY);

  // R3
  inact_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_INACT |=> state == S_INACT);
  // R8
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_STBY |=> state == S_STBY);
  // R9
  pp_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_push_pull) |-> $past(cmd_valid && cmd_index == C_ADDR && !cmd_bcast));
  // R7
  rca_by_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rca) |-> $past(cmd_valid && cmd_index == C_ADDR && !cmd_bcast));
  // R11
  rsp_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid));
  // R5
  cid_in_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == K_CID) |-> state == S_IDENT);
endmodule

// File: tb/test_card_ident_fsm.sv
module test_card_ident_fsm;
  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic        bc;
    logic [2:0]  st;
    logic        rv;
    logic [1:0]  kind;
    logic [15:0] rca;
  } vec_t;

  localparam logic [23:0]  OCR = 24'h0F8000;
  localparam logic [127:0] CID = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{6'd2,  32'h0,        1'b1, 3'd0, 1'b0, 2'd0, 16'h0},    // R11 CMD2 in idle
    '{6'd41, 32'h00FF8000, 1'b1, 3'd0, 1'b0, 2'd0, 16'h0},    // R4 no prefix
    '{6'd55, 32'h0,        1'b0, 3'd0, 1'b0, 2'd0, 16'h0},
    '{6'd41, 32'h00FF8000, 1'b1, 3'd1, 1'b1, 2'd1, 16'h0},    // R2
    '{6'd3,  32'hABCD0000, 1'b0, 3'd1, 1'b0, 2'd0, 16'h0},    // R11 addr in ready (mem)
    '{6'd2,  32'h0,        1'b1, 3'd2, 1'b1, 2'd2, 16'h0},    // R5
    '{6'd3,  32'h12340000, 1'b0, 3'd3, 1'b1, 2'd3, 16'h1234}, // R6
    '{6'd2,  32'h0,        1'b1, 3'd3, 1'b0, 2'd0, 16'h1234}, // R8
    '{6'd55, 32'h0,        1'b0, 3'd3, 1'b0, 2'd0, 16'h1234},
    '{6'd41, 32'h00FF8000, 1'b1, 3'd3, 1'b0, 2'd0, 16'h1234}, // R8
    '{6'd3,  32'h56780000, 1'b0, 3'd3, 1'b1, 2'd3, 16'h5678}, // R7
    '{6'd5,  32'h00FF8000, 1'b1, 3'd3, 1'b0, 2'd0, 16'h5678}  // R8
  };

  logic clk = 0, rst_n = 0, io_mode = 0;
  logic cmd_valid = 0, cmd_bcast = 0;
  logic [5:0] cmd_index = 0;
  logic [31:0] cmd_arg = 0;
  logic rsp_valid, drv_push_pull;
  logic [1:0] rsp_kind;
  logic [127:0] rsp_data;
  logic [2:0] state;
  logic [15:0] rca;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  card_ident_fsm i_card_ident_fsm (
    .clk, .rst_n, .io_mode, .ocr_cfg(OCR), .cid_cfg(CID),
    .cmd_valid, .cmd_index, .cmd_arg, .cmd_bcast,
    .rsp_valid, .rsp_kind, .rsp_data, .state, .rca, .drv_push_pull);

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic io);
    rst_n = 0; io_mode = io;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    io_mode = ~io;
  endtask

  task automatic send(input logic [5:0] idx, input logic [31:0] arg, input logic bc);
    cmd_valid = 1; cmd_index = idx; cmd_arg = arg; cmd_bcast = bc;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic expect_out(input string req, input logic [2:0] st, input logic rv, input logic [1:0] k);
    check(state == st, req, state, st);
    check(rsp_valid == rv, req, rsp_valid, rv);
    if (rv) check(rsp_kind == k, req, rsp_kind, k);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    #1;
    check(state == 0 && rca == 0 && !rsp_valid && !drv_push_pull, "R1 in reset", state, 0);
    do_reset(1'b0);
    check(state == 0 && rca == 0 && !rsp_valid && !drv_push_pull, "R1 after reset", state, 0);

    for (int i = 0; i < NV; i++) begin
      send(TBL[i].idx, TBL[i].arg, TBL[i].bc);
      expect_out($sformatf("table[%0d]", i), TBL[i].st, TBL[i].rv, TBL[i].kind);
      check(rca == TBL[i].rca, "R6/R7 rca", rca, TBL[i].rca);
      check(drv_push_pull == (TBL[i].st == 3'd3), "R9 driver mode", drv_push_pull, TBL[i].st == 3'd3);
      if (TBL[i].rv && TBL[i].kind == 2'd1) check(rsp_data == {104'h0, OCR}, "R2 payload", rsp_data, {104'h0, OCR});
      if (TBL[i].rv && TBL[i].kind == 2'd2) check(rsp_data == CID, "R5 payload", rsp_data, CID);
      if (TBL[i].rv && TBL[i].kind == 2'd3) check(rsp_data == {96'h0, TBL[i].rca, 16'h0}, "R6 payload", rsp_data, {96'h0, TBL[i].rca, 16'h0});
    end

    // R4: intervening command clears the pending prefix
    do_reset(1'b0);
    send(6'd55, 0, 0);
    send(6'd7, 0, 0);
    send(6'd41, 32'h00FF8000, 1);
    expect_out("R4 intervening cmd", 3'd0, 1'b0, 2'd0);

    // R3: mismatch goes inactive after replying
    do_reset(1'b0);
    send(6'd55, 0, 0);
    send(6'd41, 32'h00000F00, 1);
    expect_out("R3 mismatch reply", 3'd4, 1'b1, 2'd1);
    send(6'd55, 0, 0);
    send(6'd41, 32'h00FF8000, 1);
    expect_out("R3 inactive ignores op", 3'd4, 1'b0, 2'd0);
    send(6'd3, 32'h11110000, 0);
    expect_out("R3 inactive ignores addr", 3'd4, 1'b0, 2'd0);
    check(rca == 0, "R3 rca untouched", rca, 0);

    // R10, R12: I/O card (io_mode flips to 0 right after reset)
    do_reset(1'b1);
    send(6'd2, 0, 1);
    expect_out("R10 io ignores CMD2", 3'd0, 1'b0, 2'd0);
    send(6'd55, 0, 0);
    send(6'd41, 32'h00FF8000, 1);
    expect_out("R10 io ignores ACMD41", 3'd0, 1'b0, 2'd0);
    send(6'd5, 32'h00FF8000, 0);
    expect_out("R11 CMD5 not broadcast", 3'd0, 1'b0, 2'd0);
    send(6'd5, 32'h00FF8000, 1);
    expect_out("R12 R10 io op cond", 3'd1, 1'b1, 2'd1);
    send(6'd3, 32'h9ABC0000, 1);
    expect_out("R11 CMD3 broadcast", 3'd1, 1'b0, 2'd0);
    send(6'd3, 32'h9ABC0000, 0);
    expect_out("R10 io addr", 3'd3, 1'b1, 2'd3);
    check(rca == 16'h9ABC, "R10 io rca", rca, 16'h9ABC);
    check(drv_push_pull, "R9 io push-pull", drv_push_pull, 1);

    // R3 via I/O mismatch
    do_reset(1'b1);
    send(6'd5, 32'h00000001, 1);
    expect_out("R3 io mismatch", 3'd4, 1'b1, 2'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule